// File: doc/BRIEF.md
# Multi-Master Bus Arbiter with Lock Hold and Split Parking

This block decides which of up to sixteen bus masters may drive the next address phase on a shared, pipelined on-chip bus. Each master raises a request line to ask for the bus and can raise a lock line to keep it for an indivisible run of transfers. The arbiter returns a one-hot grant vector to the masters. It also gives the slaves the number of the master whose address phase is on the bus, and a flag that marks that address phase as part of a locked run.

The grant can change only on a clock edge where the bus ready signal is high. Among the eligible requesters, the lowest master number wins. When nobody is eligible, master 0 takes the bus as the default owner. A slave can answer a transfer with the split response code. The master that owns that data phase is then parked: it is left out of arbitration until a split-capable slave raises that master's bit in its release vector.

The master number and the lock flag move with the address phase. They take the grant owner's number and lock level one ready edge after the grant was given. A split response is charged to the master that owned the address phase one ready edge before that.

Top module: `bus_arbiter`

## Requirements
- R1: When reset (rst_n low, asynchronous) is released, grant_o is 1 (master 0), master_id_o is 0 and master_lock_o is 0.
- R2: grant_o always has exactly one bit set.
- R3: On a ready edge with no lock hold, the grant goes to the lowest-numbered master whose request is high and which is not parked.
- R4: On a ready edge with no eligible requester and no lock hold, master 0 receives the grant.
- R5: On an edge where bus_ready_i is low, grant_o does not change.
- R6: On each ready edge, master_id_o takes the number of the master granted just before that edge. On edges where bus_ready_i is low, master_id_o does not change.
- R7: On each ready edge, master_lock_o takes the level of lock_i of the master granted just before that edge.
- R8: While the granted master holds its lock_i bit high and is not parked, the grant stays with it on ready edges, even if lower-numbered masters request. Once its lock drops, normal arbitration resumes.
- R9: resp_i equal to 2'b11 (split) parks the data-phase owner. The data-phase owner is the value master_id_o held before the most recent ready edge. A parked master cannot keep or win the grant, even if it is locking.
- R10: A parked master m is released when any slave s raises bit s*NUM_MASTERS+m of split_release_i. It can win the grant on that same edge.
- R11: If a split response and a release for the same master arrive in the same cycle, the master stays parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_MASTERS | Bus request, one bit per master |
| lock_i | input | NUM_MASTERS | Locked-run request, one bit per master |
| bus_ready_i | input | 1 | Bus ready; high completes the current transfer |
| resp_i | input | 2 | Slave response code: 00 okay, 01 error, 10 retry, 11 split |
| split_release_i | input | NUM_SPLIT_SLAVES*NUM_MASTERS | Per-slave release vectors, slave s at bits s*NUM_MASTERS upward |
| grant_o | output | NUM_MASTERS | One-hot grant |
| master_id_o | output | 4 | Number of the master owning the address phase |
| master_lock_o | output | 1 | Address phase belongs to a locked run |

## Verification
Priority is tried with sparse, single-bit-high, full and empty request patterns. These separate lowest-first selection from highest-first selection and from the default fallback. Holding ready low while a new request waits shows that handover is gated by ready, and that the master number moves only on ready edges. A locked master with a lower-numbered competitor separates lock hold from plain priority. A split, then a release, then a split and release in the same cycle, show the parking order and the precedence of the split code.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int MAX_MASTERS = 16;
    localparam int MASTER_ID_W = 4;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } resp_e;

endpackage

// File: rtl/arb_lowest_pick.sv
module arb_lowest_pick #(
    parameter int N   = 16,
    parameter int IDW = 4
) (
    input  logic [N-1:0]   cand_i,
    output logic           found_o,
    output logic [IDW-1:0] idx_o
);
    // scan from the top so the lowest candidate is written last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_release_merge.sv
module arb_release_merge #(
    parameter int N     = 16,
    parameter int SLAVES = 2
) (
    input  logic [SLAVES*N-1:0] vec_i,
    output logic [N-1:0]        any_o
);
    logic [N-1:0] partial [SLAVES+1];

    assign partial[0] = '0;
    for (genvar s = 0; s < SLAVES; s++) begin : g_slave
        assign partial[s+1] = partial[s] | vec_i[s*N +: N];
    end
    assign any_o = partial[SLAVES];
endmodule

// File: rtl/arb_grant_decode.sv
module arb_grant_decode #(
    parameter int N   = 16,
    parameter int IDW = 4
) (
    input  logic [IDW-1:0] idx_i,
    output logic [N-1:0]   onehot_o
);
    for (genvar m = 0; m < N; m++) begin : g_bit
        assign onehot_o[m] = (idx_i == IDW'(m));
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS      = 16,
    parameter int NUM_SPLIT_SLAVES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_MASTERS-1:0]              req_i,
    input  logic [NUM_MASTERS-1:0]              lock_i,
    input  logic                                bus_ready_i,
    input  logic [1:0]                          resp_i,
    input  logic [NUM_SPLIT_SLAVES*NUM_MASTERS-1:0] split_release_i,
    output logic [NUM_MASTERS-1:0]              grant_o,
    output logic [MASTER_ID_W-1:0]              master_id_o,
    output logic                                master_lock_o
);
    localparam int N   = NUM_MASTERS;
    localparam int IDW = MASTER_ID_W;

    typedef struct packed {
        logic [IDW-1:0] gnt_idx;    // current grant owner
        logic [IDW-1:0] addr_own;   // owner of address phase
        logic           addr_lock;  // address phase is locked
        logic [IDW-1:0] data_own;   // owner of data phase
        logic [N-1:0]   split_mask; // parked masters
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [N-1:0]   release_any;
    logic [N-1:0]   park_set;
    logic [N-1:0]   eligible;
    logic           pick_found;
    logic [IDW-1:0] pick_idx;
    logic           owner_hold;

    arb_release_merge #(.N(N), .SLAVES(NUM_SPLIT_SLAVES)) u_merge (
        .vec_i (split_release_i),
        .any_o (release_any)
    );

    arb_lowest_pick #(.N(N), .IDW(IDW)) u_pick (
        .cand_i  (eligible),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    arb_grant_decode #(.N(N), .IDW(IDW)) u_dec (
        .idx_i    (state_q.gnt_idx),
        .onehot_o (grant_o)
    );

    always_comb begin
        state_d = state_q;

        park_set = '0;
        if (resp_e'(resp_i) == RESP_SPLIT) begin
            park_set = {{(N-1){1'b0}}, 1'b1} << state_q.data_own;
        end
        // a fresh split outranks a release in the same cycle
        state_d.split_mask = (state_q.split_mask & ~release_any) | park_set;

        eligible   = req_i & ~state_d.split_mask;
        owner_hold = lock_i[state_q.gnt_idx] & ~state_d.split_mask[state_q.gnt_idx];

        if (bus_ready_i) begin
            state_d.data_own  = state_q.addr_own;
            state_d.addr_own  = state_q.gnt_idx;
            state_d.addr_lock = lock_i[state_q.gnt_idx];
            if (owner_hold) begin
                state_d.gnt_idx = state_q.gnt_idx;
            end else if (pick_found) begin
                state_d.gnt_idx = pick_idx;
            end else begin
                state_d.gnt_idx = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign master_id_o   = state_q.addr_own;
    assign master_lock_o = state_q.addr_lock;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] lock_i,
    input logic         bus_ready_i,
    input logic [1:0]   resp_i,
    input logic [N-1:0] grant_o,
    input logic [3:0]   master_id_o,
    input logic         master_lock_o,
    input logic [N-1:0] split_mask_q
);
    function automatic logic [3:0] grant_num(input logic [N-1:0] g);
        logic [3:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            if (g[i]) r = 4'(i);
        end
        return r;
    endfunction

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1);

    // R5
    grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready_i |=> $stable(grant_o));

    // R6
    id_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_i |=> master_id_o == $past(grant_num(grant_o)));

    // R6
    id_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready_i |=> $stable(master_id_o));

    // R7
    lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_i |=> master_lock_o == $past(|(lock_i & grant_o)));

    // R8
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_i && |(lock_i & grant_o) && resp_i != 2'b11 &&
         !(|(grant_o & split_mask_q))) |=> $stable(grant_o));
endmodule

bind bus_arbiter arb_checker #(.N(NUM_MASTERS)) u_arb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lock_i        (lock_i),
    .bus_ready_i   (bus_ready_i),
    .resp_i        (resp_i),
    .grant_o       (grant_o),
    .master_id_o   (master_id_o),
    .master_lock_o (master_lock_o),
    .split_mask_q  (state_q.split_mask)
);

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
    localparam int N = 16;
    localparam int S = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_i = '0;
    logic [N-1:0]   lock_i = '0;
    logic           bus_ready_i = 1'b1;
    logic [1:0]     resp_i = 2'b00;
    logic [S*N-1:0] split_release_i = '0;
    logic [N-1:0]   grant_o;
    logic [3:0]     master_id_o;
    logic           master_lock_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bus_arbiter #(.NUM_MASTERS(N), .NUM_SPLIT_SLAVES(S)) u_bus_arbiter (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .lock_i          (lock_i),
        .bus_ready_i     (bus_ready_i),
        .resp_i          (resp_i),
        .split_release_i (split_release_i),
        .grant_o         (grant_o),
        .master_id_o     (master_id_o),
        .master_lock_o   (master_lock_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_grant(input string tag, input int m);
        check(grant_o == N'(1) << m, tag, int'(grant_o), 1 << m);
    endtask

    task automatic clear_inputs();
        req_i = '0; lock_i = '0; bus_ready_i = 1'b1; resp_i = 2'b00; split_release_i = '0;
    endtask

    task automatic t_reset();
        check(grant_o == 16'h0001, "R1 grant", int'(grant_o), 1);
        check(master_id_o == 4'd0, "R1 id", int'(master_id_o), 0);
        check(master_lock_o == 1'b0, "R1 lock", int'(master_lock_o), 0);
    endtask

    task automatic t_priority();
        req_i = 16'hA0A0; step(); chk_grant("R3 sparse", 5);
        check($countones(grant_o) == 1, "R2 onehot", $countones(grant_o), 1);
        req_i = 16'h8000; step(); chk_grant("R3 top", 15);
        req_i = 16'hFFFF; step(); chk_grant("R3 full", 0);
        req_i = 16'h0000; step(); chk_grant("R4 default", 0);
        req_i = 16'h0040; step(); chk_grant("R3 single", 6);
        step();
        check(master_id_o == 4'd6, "R6 id follows", int'(master_id_o), 6);
        req_i = '0; step(); step();
    endtask

    task automatic t_ready_gate();
        // owner is 0 here, id 0
        bus_ready_i = 1'b0; req_i = 16'h0004;
        step(); chk_grant("R5 wait1", 0);
        step(); step(); chk_grant("R5 wait3", 0);
        bus_ready_i = 1'b1; step(); chk_grant("R5 handover", 2);
        check(master_id_o == 4'd0, "R6 id lags", int'(master_id_o), 0);
        bus_ready_i = 1'b0; step();
        check(master_id_o == 4'd0, "R6 id frozen", int'(master_id_o), 0);
        bus_ready_i = 1'b1; step();
        check(master_id_o == 4'd2, "R6 id update", int'(master_id_o), 2);
        req_i = '0; step(); step();
    endtask

    task automatic t_lock();
        req_i = 16'h0020; lock_i = 16'h0020; step(); chk_grant("R8 take", 5);
        req_i = 16'h0022; step(); chk_grant("R8 hold1", 5);
        check(master_lock_o == 1'b1, "R7 lock flag", int'(master_lock_o), 1);
        check(master_id_o == 4'd5, "R6 locked id", int'(master_id_o), 5);
        step(); step(); chk_grant("R8 hold3", 5);
        lock_i = '0; step(); chk_grant("R8 release", 1);
        step();
        check(master_lock_o == 1'b0, "R7 flag drop", int'(master_lock_o), 0);
        req_i = '0; step(); step();
    endtask

    task automatic t_split();
        req_i = 16'h0008; step(); chk_grant("R9 own", 3);
        step(); step(); // master 3 now in data phase
        check(master_id_o == 4'd3, "R9 id", int'(master_id_o), 3);
        step(); // data owner is 3
        resp_i = 2'b11; bus_ready_i = 1'b0; step();
        chk_grant("R5 split wait", 3);
        bus_ready_i = 1'b1; step(); chk_grant("R9 parked", 0);
        resp_i = 2'b00; step(); step(); chk_grant("R9 stays parked", 0);
        split_release_i = 32'h0008_0000; step(); chk_grant("R10 release slave1", 3);
        split_release_i = '0; step(); step();
        check(master_id_o == 4'd3, "R11 id", int'(master_id_o), 3);
        step();
        resp_i = 2'b11; split_release_i = 32'h0000_0008; step();
        chk_grant("R11 split wins", 0);
        resp_i = 2'b00; split_release_i = '0; step(); step();
        chk_grant("R11 still parked", 0);
        lock_i = 16'h0008; step(); chk_grant("R9 lock no help", 0);
        split_release_i = 32'h0000_0008; step(); chk_grant("R10 release slave0", 3);
        split_release_i = '0; lock_i = '0; req_i = '0; step(); step();
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_inputs();
        #35 rst_n = 1'b1;
        #2;
        t_reset();
        step();
        t_priority();
        t_ready_gate();
        t_lock();
        t_split();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule